// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers one-cycle event pulses from the transmit path, the receive path, the bus interface and the PHY. It records them in a 32-bit sticky status register. A read of that register returns the recorded events and wipes them in the same cycle. Events that land in the very cycle of that read are not lost: they stay recorded for the next read.

Next to the status register sit a mask register with the same bit layout and a one-bit global enable. A single level interrupt line is raised while the enable is set and any masked status bit is set. Status bit 15 is not recorded at all. It is a live OR over the bus-side and reset-completion events in bits 16 to 25, so one mask bit can gate that whole group.

Software reaches the unit through a word-indexed register port. A request is accepted in every cycle in which `req_valid` is high; the port never applies back-pressure. A read returns its data with `rsp_valid` exactly one cycle after the request. Word 0 is status (reading it clears it; writes to it are ignored). Word 1 is mask. Word 2 is the enable. Word 3 is a command word that reads as zero.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status, mask and enable registers all read as zero, `irq` is low and `rsp_valid` is low.
- R2: A pulse on a recorded event input sets the matching status bit, and the bit stays set until a status read. The recorded bits are 0 to 14, 16 and 20 to 25.
- R3: A read request to word 0 returns the current status on `rsp_rdata`, with `rsp_valid` high, one cycle after the request. The same clock edge clears every recorded bit.
- R4: An event pulse, or a software-interrupt command, arriving in the same cycle as a status read is absent from that read's data and is present in the next read.
- R5: Status bit 15 reads as the OR of status bits 25 down to 16. It drops as soon as those bits are cleared.
- R6: Bits 15, 17 to 19 and 26 to 31 of `ev_i` have no effect: those status positions never latch (bit 15 reads only its live OR), bits 17 to 19 and 26 to 31 always read zero, and writes to word 0 change nothing.
- R7: Word 1 is the read/write mask. Only bits 0 to 16 and 20 to 25 are stored; all other bits read zero.
- R8: Bit 0 of word 2 is the global interrupt enable. Bits 31 to 1 of word 2 read zero.
- R9: `irq` is high exactly when the enable is set and the AND of status (including bit 15) and mask is non-zero. It follows register changes with no extra cycle of delay.
- R10: Writing word 3 with data bit 0 set raises status bit 12 at the next edge. Word 3 always reads zero.
- R11: Reads of words 1, 2 and 3 leave the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 32 | Event pulses, one bit per status position |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Word index: 0 status, 1 mask, 2 enable, 3 command |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Level interrupt output |

## Verification
The checker watches several properties on every cycle. It confirms that recorded bits persist until a status read. It confirms that an event coinciding with a clearing read survives that read. It confirms that read data equals the status seen on the request cycle, with bit 15 equal to the OR of bits 25 to 16 and the empty positions at zero. It also confirms that `irq` is never high without the enable and never high without a masked cause. The bench scenarios show the properties that depend on a sequence of register accesses: the exact mask and enable read-back patterns, the software-interrupt command, the summary bit acting as a mask gate, and the fact that non-status reads do not clear.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 2;
  localparam int SWI_BIT = 12;
  localparam int SUM_BIT = 15;
  localparam int SUM_LO  = 16;
  localparam int SUM_HI  = 25;
  // positions that hold a sticky flop
  localparam logic [REG_W-1:0] LATCH_BITS = 32'h03F1_7FFF;
  // positions that can read non-zero (adds the summary bit)
  localparam logic [REG_W-1:0] READ_BITS  = LATCH_BITS | (32'h1 << SUM_BIT);

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_CMD    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
`timescale 1ns/1ps
module irq_status_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] LATCH = '0,
  parameter int SUM_BIT = 15,
  parameter int SUM_LO = 16,
  parameter int SUM_HI = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_all,
  input  logic         clr_rd,
  output logic [W-1:0] status_q,
  output logic [W-1:0] status_view
);
  logic [W-1:0] ev_kept;
  assign ev_kept = ev_all & LATCH;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LATCH[i]) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      status_q[i] <= 1'b0;
        else if (clr_rd) status_q[i] <= ev_kept[i];
        else             status_q[i] <= status_q[i] | ev_kept[i];
      end
    end else begin : g_none
      assign status_q[i] = 1'b0;
    end
  end

  always_comb begin
    status_view          = status_q;
    status_view[SUM_BIT] = |status_q[SUM_HI:SUM_LO];
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
`timescale 1ns/1ps
module irq_ctrl_regs #(
  parameter int W = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_wr,
  input  logic         en_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q,
  output logic         en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= wdata & KEEP;
      if (en_wr)   en_q   <= wdata[0];
    end
  end
endmodule

// File: rtl/irq_rd_port.sv
`timescale 1ns/1ps
module irq_rd_port
  import irq_pkg::*;
#(
  parameter int W = 32,
  parameter int AW = 2,
  parameter int SWI_BIT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [W-1:0]  req_wdata,
  input  logic [W-1:0]  status_view,
  input  logic [W-1:0]  mask_q,
  input  logic          en_q,
  output logic          stat_rd,
  output logic          mask_wr,
  output logic          en_wr,
  output logic [W-1:0]  swi_vec,
  output logic          rsp_valid,
  output logic [W-1:0]  rsp_rdata
);
  reg_sel_e     sel;
  logic         rd_go;
  logic         wr_go;
  logic [W-1:0] rd_mux;

  assign sel   = reg_sel_e'(req_addr);
  assign rd_go = req_valid & ~req_write;
  assign wr_go = req_valid & req_write;

  always_comb begin
    stat_rd = rd_go & (sel == SEL_STATUS);
    mask_wr = wr_go & (sel == SEL_MASK);
    en_wr   = wr_go & (sel == SEL_ENABLE);
    swi_vec = '0;
    swi_vec[SWI_BIT] = wr_go & (sel == SEL_CMD) & req_wdata[0];
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS: rd_mux = status_view;
      SEL_MASK:   rd_mux = mask_q;
      SEL_ENABLE: rd_mux = {{(W-1){1'b0}}, en_q};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_go;
      if (rd_go) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_gate.sv
`timescale 1ns/1ps
module irq_gate #(
  parameter int W = 32
) (
  input  logic [W-1:0] status_view,
  input  logic [W-1:0] mask_q,
  input  logic         en_q,
  output logic         irq
);
  assign irq = en_q & (|(status_view & mask_q));
endmodule

// File: rtl/irq_status_unit.sv
`timescale 1ns/1ps
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int AW = ADDR_W,
  parameter logic [W-1:0] LATCH = LATCH_BITS,
  parameter int SUM_POS = SUM_BIT,
  parameter int SUM_FROM = SUM_LO,
  parameter int SUM_TO = SUM_HI,
  parameter int SWI_POS = SWI_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  ev_i,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [W-1:0]  req_wdata,
  output logic          rsp_valid,
  output logic [W-1:0]  rsp_rdata,
  output logic          irq
);
  localparam logic [W-1:0] MASK_KEEP = LATCH | (W'(1) << SUM_POS);

  logic [W-1:0] status_lat;
  logic [W-1:0] status_view;
  logic [W-1:0] mask_q;
  logic         en_q;
  logic         stat_rd;
  logic         mask_wr;
  logic         en_wr;
  logic [W-1:0] swi_vec;
  logic [W-1:0] ev_all;

  assign ev_all = ev_i | swi_vec;

  irq_status_bank #(
    .W(W), .LATCH(LATCH), .SUM_BIT(SUM_POS), .SUM_LO(SUM_FROM), .SUM_HI(SUM_TO)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .ev_all(ev_all), .clr_rd(stat_rd),
    .status_q(status_lat), .status_view(status_view)
  );

  irq_ctrl_regs #(.W(W), .KEEP(MASK_KEEP)) u_regs (
    .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .en_wr(en_wr),
    .wdata(req_wdata), .mask_q(mask_q), .en_q(en_q)
  );

  irq_rd_port #(.W(W), .AW(AW), .SWI_BIT(SWI_POS)) u_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .status_view(status_view),
    .mask_q(mask_q), .en_q(en_q), .stat_rd(stat_rd), .mask_wr(mask_wr),
    .en_wr(en_wr), .swi_vec(swi_vec), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  irq_gate #(.W(W)) u_gate (
    .status_view(status_view), .mask_q(mask_q), .en_q(en_q), .irq(irq)
  );
endmodule

// File: rtl/irq_status_unit_chk.sv
`timescale 1ns/1ps
module irq_status_unit_chk #(
  parameter int W = 32,
  parameter logic [W-1:0] LATCH = 32'h03F1_7FFF
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] ev_i,
  input logic         req_valid,
  input logic         req_write,
  input logic [1:0]   req_addr,
  input logic         rsp_valid,
  input logic [W-1:0] rsp_rdata,
  input logic         irq,
  input logic [W-1:0] status_lat,
  input logic [W-1:0] mask_q,
  input logic         en_q
);
  logic st_rd;
  logic en_rd;
  assign st_rd = req_valid && !req_write && req_addr == 2'd0;
  assign en_rd = req_valid && !req_write && req_addr == 2'd2;

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !st_rd |=> ((status_lat & $past(status_lat)) == $past(status_lat)));

  a_r3_read_data: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd |=> (rsp_valid && ((rsp_rdata & LATCH) == $past(status_lat))));

  a_r4_race_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && ((ev_i & LATCH) != '0)) |=>
      ((status_lat & $past(ev_i & LATCH)) == $past(ev_i & LATCH)));

  a_r5_summary: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd |=> (rsp_rdata[15] == (|rsp_rdata[25:16])));

  a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd |=> (rsp_rdata[31:26] == '0 && rsp_rdata[19:17] == '0));

  a_r8_enable_width: assert property (@(posedge clk) disable iff (!rst_n)
    en_rd |=> (rsp_rdata[W-1:1] == '0));

  a_r9_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !irq);

  a_r9_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status_lat & mask_q) != '0 || (mask_q[15] && status_lat[25:16] != '0)));
endmodule

bind irq_status_unit irq_status_unit_chk #(.W(W), .LATCH(LATCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .req_valid(req_valid),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .irq(irq), .status_lat(status_lat),
  .mask_q(mask_q), .en_q(en_q)
);

// File: tb/irq_status_unit_tb_top.sv
`timescale 1ns/1ps
module irq_status_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ev_i = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  irq_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every read response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_exp.size() == 0) chk("R3 unexpected response", 32'd1, 32'd0);
      else begin
        logic [31:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(t, rsp_rdata, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag,
                    input logic [31:0] ev = '0);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; ev_i = ev;
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0; ev_i = '0;
  endtask

  task automatic pulse(input logic [31:0] ev);
    ev_i = ev;
    @(negedge clk);
    ev_i = '0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    rd(2'd0, 32'h0, "R1 status reset");
    rd(2'd1, 32'h0, "R1 mask reset");
    rd(2'd2, 32'h0, "R1 enable reset");

    // R2/R3 latch and clear-on-read
    pulse(32'h0000_0001);
    pulse(32'h0000_0040);
    rd(2'd0, 32'h0000_0041, "R2 R3 two events latched");
    rd(2'd0, 32'h0, "R3 cleared by read");

    // R5 summary bit
    pulse(32'h0020_0000);
    rd(2'd0, 32'h0020_8000, "R5 summary with bit21");
    rd(2'd0, 32'h0, "R5 summary drops");

    // R6 unrecorded positions and status writes
    pulse(32'hFC0E_8000);
    rd(2'd0, 32'h0, "R6 unrecorded events ignored");
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'h0, "R6 status write ignored");

    // R7/R8 read-back patterns
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h03F1_FFFF, "R7 mask keeps implemented bits");
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, 32'h0000_0001, "R8 enable one bit");

    // R9 interrupt gating
    wr(2'd1, 32'h0000_0080);
    pulse(32'h0000_0040);
    chk("R9 unmasked event no irq", {31'd0, irq}, 32'd0);
    pulse(32'h0000_0080);
    chk("R9 masked event raises irq", {31'd0, irq}, 32'd1);
    rd(2'd0, 32'h0000_00C0, "R9 status content");
    chk("R9 irq drops after read", {31'd0, irq}, 32'd0);
    wr(2'd1, 32'h0000_8000);
    pulse(32'h0100_0000);
    chk("R9 R5 summary bit gates irq", {31'd0, irq}, 32'd1);
    wr(2'd2, 32'h0);
    chk("R9 enable off masks irq", {31'd0, irq}, 32'd0);
    rd(2'd0, 32'h0100_8000, "R9 status with bit24");

    // R4 race between event and clearing read
    pulse(32'h0000_0004);
    rd(2'd0, 32'h0000_0004, "R4 read excludes same-cycle event", 32'h0000_0010);
    rd(2'd0, 32'h0000_0010, "R4 same-cycle event kept");

    // R10 software interrupt command
    wr(2'd3, 32'h0000_0001);
    rd(2'd0, 32'h0000_1000, "R10 command sets bit12");
    rd(2'd3, 32'h0, "R10 command reads zero");
    wr(2'd3, 32'h0000_0000);
    rd(2'd0, 32'h0, "R10 zero command no effect");

    // R11 other reads do not clear
    pulse(32'h0000_0008);
    rd(2'd1, 32'h0000_8000, "R11 mask read");
    rd(2'd2, 32'h0, "R11 enable read");
    rd(2'd3, 32'h0, "R11 command read");
    rd(2'd0, 32'h0000_0008, "R11 status survives other reads");

    @(negedge clk);
    @(negedge clk);
    chk("R3 all responses seen", q_exp.size(), 32'd0);
    finish_run();
  end
endmodule